// File: doc/BRIEF.md
# Selectable Logging End-Trigger Generator

This block produces the single-cycle end trigger that stops a logging capture. The trigger comes from one of two sources. The first is a user-selected source: an 8-bit select code picks one signal from a pool made of filtered digital input bits, post-control digital output bits and one user control bit. The block detects the rising edge of that signal and turns it into a one-clock pulse. The second source is a time-division path. A flag is set by a time-division enable and cleared by a separate clear input, with set taking priority when both are asserted together. The flag's rising edge forms a one-clock pulse of its own.

A mode input decides which of the two pulses reaches the output. The output is held in a flip-flop on the block clock. Input filtering, output control, register decoding and the logging memory all sit outside this block.

Top module: `logend_trig_gen`

## Requirements
- R1: Select codes 0x01 to 0x0A choose filtered input bits 0 to 9, in that order. A 0-to-1 change on the chosen bit gives `end_trig` = 1 after the next rising clock edge while `mode_td` = 0.
- R2: Select codes 0x0B to 0x14 choose post-control output bits 0 to 9, in that order, with the same pulse behaviour as R1.
- R3: Select code 0x15 chooses `usr_ctl_bit`, with the same pulse behaviour as R1.
- R4: Any select code other than 0x01 to 0x15 (0x00 and 0x16 to 0xFF) makes the chosen signal a constant 0. With such a code, `end_trig` stays 0 whatever the source inputs do.
- R5: A selected signal that rises and then stays high gives a pulse exactly one clock long. `end_trig` returns to 0 on the following edge.
- R6: The time-division flag behaves as follows:
  - it is set at a clock edge when `td_set` = 1, even if `td_clr` = 1 at the same edge;
  - it is cleared when only `td_clr` = 1;
  - it holds its value otherwise.
  
  A 0-to-1 change of the flag gives a one-cycle `end_trig` pulse two edges after `td_set` is sampled, while `mode_td` = 1.
- R7: `mode_td` = 0 routes the user-selected pulse to `end_trig`, and `mode_td` = 1 routes the time-division pulse. The pulse of the path that is not selected has no effect on `end_trig`.
- R8: `rst` is synchronous and active high. It clears both edge histories, the flag and `end_trig`. `end_trig` is 0 during reset and in the first cycle after release. A selected level that is already high at release counts as a rising edge and pulses after the first edge following release.
- R9: The edge history follows whichever signal is currently selected. If the select code moves from a low source to a high source, one pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (100 MHz domain) |
| rst | input | 1 | Synchronous active-high reset |
| sel_code | input | 8 | Source select code for the user path |
| din_bits | input | 10 | Filtered digital input bits |
| dout_bits | input | 10 | Post-control digital output bits |
| usr_ctl_bit | input | 1 | User logging control bit |
| td_set | input | 1 | Time-division enable (sets the flag) |
| td_clr | input | 1 | Time-division clear (resets the flag) |
| mode_td | input | 1 | 0 = user path, 1 = time-division path |
| end_trig | output | 1 | Registered one-cycle end trigger |

## Verification
The assertions assume the following about the inputs:
- every input is synchronous to `clk` and never unknown once reset is applied;
- `mode_td` holds still in the cycle around a pulse, because the one-cycle-width property only applies while the mode is stable.

The stimulus respects this by changing every input one time unit after a rising edge. It also changes `mode_td` only while both paths are quiet, before it raises a source. The invalid-code property relies on the select code and mode being settled in the cycle before the output edge, and the bench sets both of these before it raises any source bit.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [0:0] {
      TRIG_MODE_USR = 1'b0,
      TRIG_MODE_TD  = 1'b1
   } trig_mode_e;

   localparam int unsigned TRIG_CODE_BASE = 1;
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
   parameter int unsigned NUM_IN     = 10,
   parameter int unsigned NUM_OUT    = 10,
   parameter int unsigned CODE_W     = 8,
   parameter bit          ONEHOT_DEC = 1'b1
) (
   input  logic [CODE_W-1:0]  sel_code,
   input  logic [NUM_IN-1:0]  din_bits,
   input  logic [NUM_OUT-1:0] dout_bits,
   input  logic               usr_ctl_bit,
   output logic               sel_sig
);
   import trig_pkg::*;

   localparam int unsigned NUM_SRC   = NUM_IN + NUM_OUT + 1;
   localparam int unsigned FIRST_CODE = TRIG_CODE_BASE;
   localparam int unsigned LAST_CODE  = TRIG_CODE_BASE + NUM_SRC - 1;
   localparam int unsigned IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   logic [NUM_SRC-1:0] cand;
   assign cand = {usr_ctl_bit, dout_bits, din_bits};

   generate
      if (ONEHOT_DEC) begin : g_onehot
         logic [NUM_SRC-1:0] hit;
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign hit[i] = cand[i] & (sel_code == CODE_W'(FIRST_CODE + i));
         end
         assign sel_sig = |hit;
      end else begin : g_index
         logic              in_range;
         logic [CODE_W-1:0] offs;
         assign in_range = (sel_code >= CODE_W'(FIRST_CODE)) &&
                           (sel_code <= CODE_W'(LAST_CODE));
         assign offs     = sel_code - CODE_W'(FIRST_CODE);
         assign sel_sig  = in_range ? cand[offs[IDX_W-1:0]] : 1'b0;
      end
   endgenerate
endmodule

// File: rtl/trig_rise_det.sv
module trig_rise_det (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);
   logic hist_q;

   always_ff @(posedge clk) begin
      if (rst) hist_q <= 1'b0;
      else     hist_q <= lvl;
   end

   assign rise = lvl & ~hist_q;
endmodule

// File: rtl/trig_sr_flag.sv
module trig_sr_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic flag
);
   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_dom
         always_ff @(posedge clk) begin
            if (rst)        flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
         end
      end else begin : g_clr_dom
         always_ff @(posedge clk) begin
            if (rst)        flag_q <= 1'b0;
            else if (clr_i) flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag = flag_q;
endmodule

// File: rtl/logend_trig_gen.sv
module logend_trig_gen #(
   parameter int unsigned NUM_IN     = 10,
   parameter int unsigned NUM_OUT    = 10,
   parameter int unsigned CODE_W     = 8,
   parameter bit          ONEHOT_DEC = 1'b1,
   parameter bit          TD_SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [CODE_W-1:0]  sel_code,
   input  logic [NUM_IN-1:0]  din_bits,
   input  logic [NUM_OUT-1:0] dout_bits,
   input  logic               usr_ctl_bit,
   input  logic               td_set,
   input  logic               td_clr,
   input  logic               mode_td,
   output logic               end_trig
);
   import trig_pkg::*;

   localparam int unsigned NUM_SRC  = NUM_IN + NUM_OUT + 1;
   localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

   generate
      if (NUM_IN < 1 || NUM_OUT < 1) begin : g_bad_width
         $error("logend_trig_gen: source counts must be at least 1");
      end
      if (TRIG_CODE_BASE + NUM_SRC - 1 > MAX_CODE) begin : g_bad_code
         $error("logend_trig_gen: select code too narrow for source pool");
      end
   endgenerate

   logic sel_sig;
   logic usr_pulse;
   logic td_flag;
   logic td_pulse;
   logic trig_d;
   logic trig_q;

   trig_src_mux #(
      .NUM_IN     (NUM_IN),
      .NUM_OUT    (NUM_OUT),
      .CODE_W     (CODE_W),
      .ONEHOT_DEC (ONEHOT_DEC)
   ) u_mux (
      .sel_code    (sel_code),
      .din_bits    (din_bits),
      .dout_bits   (dout_bits),
      .usr_ctl_bit (usr_ctl_bit),
      .sel_sig     (sel_sig)
   );

   trig_rise_det u_usr_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (sel_sig),
      .rise (usr_pulse)
   );

   trig_sr_flag #(
      .SET_WINS (TD_SET_WINS)
   ) u_td_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (td_set),
      .clr_i (td_clr),
      .flag  (td_flag)
   );

   trig_rise_det u_td_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (td_flag),
      .rise (td_pulse)
   );

   always_comb begin
      trig_d = usr_pulse;
      if (trig_mode_e'(mode_td) == TRIG_MODE_TD) trig_d = td_pulse;
   end

   always_ff @(posedge clk) begin
      if (rst) trig_q <= 1'b0;
      else     trig_q <= trig_d;
   end

   assign end_trig = trig_q;
endmodule

// File: rtl/logend_trig_chk.sv
module logend_trig_chk #(
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned LAST_CODE = 21
) (
   input logic              clk,
   input logic              rst,
   input logic [CODE_W-1:0] sel_code,
   input logic              mode_td,
   input logic              td_set,
   input logic              td_clr,
   input logic              td_flag,
   input logic              end_trig
);
   logic code_bad;
   assign code_bad = (sel_code == '0) || (sel_code > CODE_W'(LAST_CODE));

   p_single_cycle_r5: assert property (@(posedge clk) disable iff (rst)
      (end_trig && $stable(mode_td)) |=> !end_trig);

   p_quiet_after_reset_r8: assert property (@(posedge clk)
      $fell(rst) |-> !end_trig);

   p_invalid_code_r4: assert property (@(posedge clk) disable iff (rst)
      (!mode_td && code_bad) |=> !end_trig);

   p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      td_set |=> td_flag);

   p_clear_only_r6: assert property (@(posedge clk) disable iff (rst)
      (td_clr && !td_set) |=> !td_flag);

   p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!td_set && !td_clr) |=> $stable(td_flag));
endmodule

bind logend_trig_gen logend_trig_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .sel_code (sel_code),
   .mode_td  (mode_td),
   .td_set   (td_set),
   .td_clr   (td_clr),
   .td_flag  (td_flag),
   .end_trig (end_trig)
);

// File: tb/logend_trig_gen_tb.sv
module logend_trig_gen_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] sel_code = 8'h00;
   logic [9:0] din_bits = '0;
   logic [9:0] dout_bits = '0;
   logic       usr_ctl_bit = 1'b0;
   logic       td_set = 1'b0;
   logic       td_clr = 1'b0;
   logic       mode_td = 1'b0;
   logic       end_trig;

   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   logend_trig_gen u_dut (
      .clk         (clk),
      .rst         (rst),
      .sel_code    (sel_code),
      .din_bits    (din_bits),
      .dout_bits   (dout_bits),
      .usr_ctl_bit (usr_ctl_bit),
      .td_set      (td_set),
      .td_clr      (td_clr),
      .mode_td     (mode_td),
      .end_trig    (end_trig)
   );

   // {code[29:22], din[21:12], dout[11:2], usr[1], expected pulse[0]}
   localparam int NVEC = 11;
   localparam logic [29:0] VEC [NVEC] = '{
      {8'h01, 10'h001, 10'h000, 1'b0, 1'b1},  // R1 first input
      {8'h05, 10'h010, 10'h000, 1'b0, 1'b1},  // R1 middle input
      {8'h0A, 10'h200, 10'h000, 1'b0, 1'b1},  // R1 last input
      {8'h05, 10'h3EF, 10'h3FF, 1'b1, 1'b0},  // R1 other bits only
      {8'h0B, 10'h000, 10'h001, 1'b0, 1'b1},  // R2 first output
      {8'h14, 10'h000, 10'h200, 1'b0, 1'b1},  // R2 last output
      {8'h14, 10'h3FF, 10'h1FF, 1'b1, 1'b0},  // R2 other bits only
      {8'h15, 10'h000, 10'h000, 1'b1, 1'b1},  // R3 user bit
      {8'h00, 10'h3FF, 10'h3FF, 1'b1, 1'b0},  // R4 code zero
      {8'h16, 10'h3FF, 10'h3FF, 1'b1, 1'b0},  // R4 just past range
      {8'hFF, 10'h3FF, 10'h3FF, 1'b1, 1'b0}   // R4 top code
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: end_trig=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string req_of(input logic [7:0] c);
      if (c >= 8'h01 && c <= 8'h0A) return "R1";
      if (c >= 8'h0B && c <= 8'h14) return "R2";
      if (c == 8'h15) return "R3";
      return "R4";
   endfunction

   task automatic quiet_sources();
      din_bits = '0; dout_bits = '0; usr_ctl_bit = 1'b0;
   endtask

   initial begin
      // R8: reset with a selected level already high
      sel_code = 8'h01; din_bits = 10'h001;
      tick(); tick();
      check("R8 in reset", end_trig, 1'b0);
      rst = 1'b0;
      check("R8 first cycle after release", end_trig, 1'b0);
      tick();
      check("R8 high level at release pulses", end_trig, 1'b1);
      tick();
      check("R8 R5 pulse ends", end_trig, 1'b0);

      // table walk: user path, R1..R5
      for (int v = 0; v < NVEC; v++) begin
         mode_td = 1'b0;
         sel_code = VEC[v][29:22];
         quiet_sources();
         tick(); tick();
         din_bits    = VEC[v][21:12];
         dout_bits   = VEC[v][11:2];
         usr_ctl_bit = VEC[v][1];
         tick();
         check(req_of(VEC[v][29:22]), end_trig, VEC[v][0]);
         tick();
         check("R5 held level gives no second pulse", end_trig, 1'b0);
         tick();
         check("R5 still low", end_trig, 1'b0);
      end

      // R9: select moves from a low source to a high source
      quiet_sources(); sel_code = 8'h01; din_bits = 10'h002;
      tick(); tick();
      check("R9 low source quiet", end_trig, 1'b0);
      sel_code = 8'h02;
      tick();
      check("R9 select change pulses", end_trig, 1'b1);
      tick();
      check("R9 single pulse", end_trig, 1'b0);

      // R6: time-division path, set alone
      quiet_sources(); sel_code = 8'h00; mode_td = 1'b1;
      td_clr = 1'b1; tick(); td_clr = 1'b0; tick(); tick();
      td_set = 1'b1; tick(); td_set = 1'b0;
      check("R6 flag edge not yet out", end_trig, 1'b0);
      tick();
      check("R6 td pulse", end_trig, 1'b1);
      tick();
      check("R6 td pulse one cycle", end_trig, 1'b0);
      tick(); tick();
      check("R6 flag hold gives no pulse", end_trig, 1'b0);

      // R6: set and clear together, set wins
      td_clr = 1'b1; tick(); td_clr = 1'b0; tick(); tick();
      td_set = 1'b1; td_clr = 1'b1; tick(); td_set = 1'b0; td_clr = 1'b0;
      tick();
      check("R6 set beats clear", end_trig, 1'b1);
      tick();
      check("R6 after set-wins pulse", end_trig, 1'b0);

      // R7: user edge ignored in time-division mode
      sel_code = 8'h15; usr_ctl_bit = 1'b0; tick(); tick();
      usr_ctl_bit = 1'b1;
      tick();
      check("R7 user edge ignored in td mode", end_trig, 1'b0);
      tick();
      check("R7 user edge ignored in td mode", end_trig, 1'b0);

      // R7: td edge ignored in user mode
      usr_ctl_bit = 1'b0; sel_code = 8'h00; mode_td = 1'b0;
      td_clr = 1'b1; tick(); td_clr = 1'b0; tick(); tick();
      td_set = 1'b1; tick(); td_set = 1'b0;
      tick();
      check("R7 td edge ignored in user mode", end_trig, 1'b0);
      tick();
      check("R7 td edge ignored in user mode", end_trig, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(200000 * 20);
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule